// File: doc/BRIEF.md
# Branch Outcome Packer

The block gathers single-bit branch decisions reported at instruction retirement and packs them into compact trace packets for a byte-oriented trace stream. Each decision is one bit. A taken conditional branch gives 1 and a not-taken one gives 0. A return to an unmodified return address is reported by the caller as a taken decision. A static mode input chooses between a one-byte short packet of up to 6 decisions and an eight-byte long packet of up to 47 decisions.

A packet is sent on its own as soon as it reaches capacity. When the surrounding trace logic is about to emit a packet of another kind, it raises a flush request. Any pending decisions then leave first as a partial packet, so the order of the stream is kept. Inside every packet a stop bit marks how many payload bits are valid. The output uses a ready/valid handshake. When a finished packet cannot move on because the output is stalled, the block holds back further decisions, and no decision is ever dropped.

Top module: `branch_outcome_packer`

## Requirements
- R1: Each accepted decision contributes one payload bit equal to `decTaken`. The newest decision sits in payload bit 0 and older decisions sit at higher positions, so the oldest is in payload bit n-1 for a packet of n decisions.
- R2: A packet of n decisions carries a stop bit of 1 at payload bit n, and every payload bit above n is 0.
- R3: In short mode (`longMode`=0) a packet has `pktBytes`=1. Its layout in `pktData` is: bit 0 is 0, payload bits 6:0 are in bits 7:1, and bits 63:8 are 0.
- R4: In long mode (`longMode`=1) a packet has `pktBytes`=8. Byte 0 is 0x02 and byte 1 is 0xA3. The 48-bit payload follows little-endian, so payload bit k is `pktData` bit 16+k.
- R5: When a decision brings the count to capacity (6 in short mode, 47 in long mode), the full packet is loaded on the same clock edge that accepts that decision, provided the output is free. The accumulator is then empty.
- R6: A flush request while decisions are pending emits them as a partial packet. A flush request with nothing pending emits nothing.
- R7: A decision and a flush request in the same cycle produce one packet that includes that decision.
- R8: While `pktValid` is high and `pktReady` is low, `pktValid`, `pktData` and `pktBytes` hold. While a completed packet waits behind a stalled output, `decReady` is low. Every decision accepted with `decReady` high appears in exactly one packet, in order.
- R9: After reset `pktValid` is 0, `decReady` is 1 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| longMode | input | 1 | 0 selects short packets, 1 selects long packets; change only during reset |
| decValid | input | 1 | A decision is offered this cycle |
| decTaken | input | 1 | Decision value: 1 taken, 0 not taken |
| decReady | output | 1 | The offered decision is accepted this cycle |
| flushReq | input | 1 | Emit pending decisions as a partial packet |
| pktValid | output | 1 | A packet is presented |
| pktReady | input | 1 | The sink takes the packet this cycle |
| pktData | output | 64 | Packet bytes, byte 0 in bits 7:0 |
| pktBytes | output | 4 | Number of valid bytes, 1 or 8 |

## Verification
Directed sequences check four things separately: exact filling in each mode, a flush with nothing pending, a decision arriving together with a flush, and a full packet stuck behind a stalled sink. Together they separate capacity-driven emission from flush-driven emission and show the back-pressure path. Random traffic with uneven offer, flush and ready rates then runs in both modes. A transaction-level model rebuilds the expected packet sequence from the accepted decisions alone. Any lost, duplicated or reordered bit, or a misplaced stop bit, shows up as a mismatch against that model.

// File: rtl/bop_pkg.sv
package bop_pkg;
  localparam int ShortCap = 6;
  localparam int LongCap  = 47;
  localparam int PayW     = LongCap + 1;
  localparam int HdrW     = 16;
  localparam int DataW    = PayW + HdrW;
  localparam int CntW     = $clog2(LongCap + 1);
  localparam int BytesW   = 4;
  localparam logic [7:0] LongHdr0 = 8'h02;
  localparam logic [7:0] LongHdr1 = 8'hA3;

  typedef struct packed {
    logic shiftEn;
    logic loadOut;
    logic clrAcc;
  } bopStrobes_t;
endpackage

// File: rtl/bop_ctrl.sv
module bop_ctrl
  import bop_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            longMode,
  input  logic            decValid,
  input  logic            flushReq,
  input  logic            outBusy,
  output logic            decReady,
  output logic [CntW-1:0] cntNext,
  output bopStrobes_t     strobes
);
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] cap;
  logic            sealed;
  logic            take;
  logic            full;
  logic            wantEmit;
  logic            load;

  always_comb begin
    cap      = longMode ? CntW'(LongCap) : CntW'(ShortCap);
    take     = decValid && !sealed;
    cntNext  = cnt + CntW'(take);
    full     = take && (cntNext == cap);
    wantEmit = sealed || full || (flushReq && (cntNext != '0));
    load     = wantEmit && !outBusy;
    decReady = !sealed;
    strobes.shiftEn = take;
    strobes.loadOut = load;
    strobes.clrAcc  = load;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      sealed <= 1'b0;
    end else begin
      cnt    <= load ? '0 : cntNext;
      sealed <= wantEmit && outBusy;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sealed |-> (cnt < cap));

  // R8
  seal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sealed && outBusy) |=> (sealed && $stable(cnt)));

  // R6
  empty_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !decValid && !sealed) |-> !strobes.loadOut);
endmodule

// File: rtl/bop_datapath.sv
module bop_datapath
  import bop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              longMode,
  input  logic              decTaken,
  input  logic              pktReady,
  input  logic [CntW-1:0]   cntNext,
  input  bopStrobes_t       strobes,
  output logic              pktValid,
  output logic [DataW-1:0]  pktData,
  output logic [BytesW-1:0] pktBytes
);
  logic [LongCap-1:0] acc;
  logic [LongCap-1:0] accNext;
  logic [PayW-1:0]    payload;
  logic [DataW-1:0]   frame;
  logic [BytesW-1:0]  frameBytes;

  always_comb begin
    accNext = strobes.shiftEn ? {acc[LongCap-2:0], decTaken} : acc;
    payload = (PayW'(1) << cntNext) | {1'b0, accNext};
    if (longMode) begin
      frame      = {payload, LongHdr1, LongHdr0};
      frameBytes = BytesW'(8);
    end else begin
      frame      = DataW'({payload[6:0], 1'b0});
      frameBytes = BytesW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      pktValid <= 1'b0;
      pktData  <= '0;
      pktBytes <= '0;
    end else begin
      acc <= strobes.clrAcc ? '0 : accNext;
      if (strobes.loadOut) begin
        pktValid <= 1'b1;
        pktData  <= frame;
        pktBytes <= frameBytes;
      end else if (pktReady) begin
        pktValid <= 1'b0;
      end
    end
  end

  // R8
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktData) && $stable(pktBytes)));

  // R3
  short_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !longMode) |-> (pktBytes == 4'd1 && !pktData[0] && pktData[63:8] == '0));

  // R4
  long_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && longMode) |-> (pktBytes == 4'd8 && pktData[15:0] == 16'hA302));

  // R2
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (longMode ? (pktData[63:16] != '0) : (pktData[7:1] != '0)));
endmodule

// File: rtl/branch_outcome_packer.sv
module branch_outcome_packer
  import bop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        longMode,
  input  logic        decValid,
  input  logic        decTaken,
  output logic        decReady,
  input  logic        flushReq,
  output logic        pktValid,
  input  logic        pktReady,
  output logic [63:0] pktData,
  output logic [3:0]  pktBytes
);
  bopStrobes_t     strobes;
  logic [CntW-1:0] cntNext;
  logic            outBusy;

  assign outBusy = pktValid && !pktReady;

  bop_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .longMode (longMode),
    .decValid (decValid),
    .flushReq (flushReq),
    .outBusy  (outBusy),
    .decReady (decReady),
    .cntNext  (cntNext),
    .strobes  (strobes)
  );

  bop_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .longMode (longMode),
    .decTaken (decTaken),
    .pktReady (pktReady),
    .cntNext  (cntNext),
    .strobes  (strobes),
    .pktValid (pktValid),
    .pktData  (pktData),
    .pktBytes (pktBytes)
  );

  // R7
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decReady && flushReq && !outBusy) |=> pktValid);
endmodule

// File: tb/branch_outcome_packer_bench.sv
module branch_outcome_packer_bench;
  logic        clk = 1'b0;
  logic        rstN, longMode, decValid, decTaken, flushReq, pktReady;
  logic        decReady, pktValid;
  logic [63:0] pktData;
  logic [3:0]  pktBytes;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit rdy = 1'b1;

  logic        bitQ[$];
  logic [63:0] expData[$];
  logic [3:0]  expBytes[$];

  always #5 clk = ~clk;

  branch_outcome_packer u_branch_outcome_packer (
    .clk(clk), .rstN(rstN), .longMode(longMode), .decValid(decValid),
    .decTaken(decTaken), .decReady(decReady), .flushReq(flushReq),
    .pktValid(pktValid), .pktReady(pktReady), .pktData(pktData), .pktBytes(pktBytes)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int capOf();
    return longMode ? 47 : 6;
  endfunction

  task automatic sealPkt();
    int n = bitQ.size();
    logic [47:0] pay = 48'd1 << n;
    for (int i = 0; i < n; i++) pay[n-1-i] = bitQ[i];
    if (longMode) begin
      expData.push_back({pay, 16'hA302});
      expBytes.push_back(4'd8);
    end else begin
      expData.push_back({56'd0, pay[6:0], 1'b0});
      expBytes.push_back(4'd1);
    end
    bitQ.delete();
  endtask

  task automatic step(input logic dv, input logic dt, input logic fl);
    @(negedge clk);
    decValid = dv; decTaken = dt; flushReq = fl; pktReady = rdy;
    #1;
    if (pktValid && pktReady) begin
      if (expData.size() == 0) begin
        chk("R8 unexpected packet", pktData, 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        chk(longMode ? "R1,R2,R4 long packet" : "R1,R2,R3 short packet",
            pktData, expData.pop_front());
        chk("R3,R4 byte count", 64'(pktBytes), 64'(expBytes.pop_front()));
      end
    end
    if (dv && decReady) begin
      bitQ.push_back(dt);
      if (bitQ.size() == capOf()) sealPkt();
    end
    if (fl && bitQ.size() != 0) sealPkt();
    @(posedge clk);
    #1;
    decValid = 1'b0; flushReq = 1'b0;
  endtask

  task automatic doReset(input logic lm);
    rstN = 1'b0; longMode = lm; decValid = 0; decTaken = 0; flushReq = 0; pktReady = 1;
    bitQ.delete(); expData.delete(); expBytes.delete();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic drain();
    rdy = 1'b1;
    step(0, 0, 1);
    repeat (4) step(0, 0, 0);
    chk("R8 all decisions delivered", 64'(expData.size() + bitQ.size()), 64'd0);
  endtask

  initial begin
    logic [63:0] held;
    void'($urandom(1234));
    doReset(1'b0);
    #1;
    chk("R9 reset pktValid", 64'(pktValid), 64'd0);
    chk("R9 reset decReady", 64'(decReady), 64'd1);

    // R6 empty flush emits nothing
    step(0, 0, 1);
    chk("R6 empty flush", 64'(pktValid), 64'd0);

    // R5 exact fill of short packet: 1,0,1,1,0,0 -> 0xD8
    step(1, 1, 0); step(1, 0, 0); step(1, 1, 0); step(1, 1, 0); step(1, 0, 0);
    chk("R5 not yet full", 64'(pktValid), 64'd0);
    step(1, 0, 0);
    chk("R5 short fill timing", 64'(pktValid), 64'd1);
    chk("R1,R2 short fill data", pktData, 64'h0000_0000_0000_00D8);
    step(0, 0, 0);

    // R7 decision with flush in same cycle
    step(1, 1, 0); step(1, 0, 0);
    step(1, 1, 1);
    chk("R7 paired flush emits", 64'(pktValid), 64'd1);
    chk("R7 paired flush data", pktData, 64'h0000_0000_0000_001A);
    step(0, 0, 0);

    // R8 stall with a second full packet waiting
    rdy = 1'b0;
    for (int i = 0; i < 6; i++) step(1, 1'(i), 0);
    held = pktData;
    for (int i = 0; i < 6; i++) step(1, 1'(~i), 0);
    chk("R8 decReady low while sealed", 64'(decReady), 64'd0);
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    chk("R8 held valid", 64'(pktValid), 64'd1);
    chk("R8 held data", pktData, held);
    rdy = 1'b1;
    repeat (3) step(0, 0, 0);
    chk("R8 decReady back", 64'(decReady), 64'd1);

    // random short traffic
    for (int i = 0; i < 3000; i++) begin
      rdy = ($urandom % 10) < 7;
      step(($urandom % 10) < 6, 1'($urandom), ($urandom % 20) == 0);
    end
    drain();

    // long mode
    doReset(1'b1);
    for (int i = 0; i < 46; i++) step(1, 1'(i % 3 == 0), 0);
    chk("R5 long not yet full", 64'(pktValid), 64'd0);
    step(1, 1, 0);
    chk("R5 long fill timing", 64'(pktValid), 64'd1);
    chk("R4 long byte count", 64'(pktBytes), 64'd8);
    step(0, 0, 0);
    step(1, 0, 1);
    chk("R7 long single decision", pktData, {46'd0, 2'b10, 16'hA302});
    step(0, 0, 0);
    for (int i = 0; i < 5000; i++) begin
      rdy = ($urandom % 10) < 6;
      step(($urandom % 10) < 7, 1'($urandom), ($urandom % 60) == 0);
    end
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule